// File: doc/BRIEF.md
# Read-only three-wire serial EEPROM responder

This block models a small serial configuration EEPROM that answers only read commands. The host cannot reach the serial pins directly. It toggles chip-select, serial clock and serial data-in by writing a control register, and it reads the serial data-out bit back from the same register. Every transaction is driven by register writes. The block treats a control-register write that takes the clock bit from 0 to 1 as one serial clock edge. On each such edge it either shifts in one command bit or shifts out one data bit.

A transaction begins with a prefix of address width plus four bits. That prefix holds a leading pad bit, a start bit, a two-bit opcode and the word address. On the last prefix edge the block decodes the command and latches a 16-bit word from a fixed table. The table holds an identification word and a 48-bit station address. The next sixteen edges send that word out, most significant bit first. The bit counter then wraps on its own, so another transaction can follow without toggling select. A second host register, the command register, is also held here. Its self-clearing reset bit always reads back as zero.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset the control readback, the command readback and the error flag are all zero.
- R2: Protocol state advances only on a control-register write that takes clock bit 2 from 0 to 1. A write that keeps the clock high, or drives it low, changes neither the data-out bit nor the bit position, whatever data-in (bit 1) it carries.
- R3: A control write that takes select bit 3 from 0 to 1 clears the command shifter and the bit counter. A partly sent command is therefore discarded.
- R4: Each prefix edge shifts data-in into the command shifter, so the first bit sent becomes the most significant bit. Once ADDR_W+4 bits have arrived, the top four bits form the opcode field and the low ADDR_W bits form the word address. The only read code is 4'b0110: a pad 0, then start 1, then opcode 10.
- R5: Edges at positions ADDR_W+4 through ADDR_W+19 put bit 15, then 14, and so on down to bit 0 of the latched word on data-out (control bit 0).
- R6: After ADDR_W+20 edges the counter and the shifter return to zero by themselves. The next edge begins a new prefix with select held high.
- R7: Word 0 reads 16'h8139. Words 7, 8 and 9 hold station-address bytes 0-1, 2-3 and 4-5 in that order, with the earlier byte in bits 7:0. Byte 0 is STATION[47:40]. Every other word reads zero.
- R8: Any opcode field other than 4'b0110 sets the error flag and latches an all-zero word. The flag stays set until reset.
- R9: Host writes to control bit 0 have no effect. Only the serial logic drives that bit.
- R10: A command-register write stores the written byte with bit 4 cleared. Bit 4 therefore always reads back 0, and the other bits read back as written.
- R11: Control bits 7:4 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control register, 1 command register |
| wr_data | input | 8 | Write data |
| ctrl_rd | output | 8 | Control register readback; bit 0 is serial data-out |
| cmd_rd | output | 8 | Command register readback |
| err | output | 1 | Sticky flag for an unsupported opcode |

## Verification
The bench hides extra writes between real clock edges. These writes hold the clock high or low, flip data-in and set bit 0. A design that treats a level as an edge, or lets the host drive data-out, returns shifted or corrupted words. A command is abandoned halfway and select is then re-raised. If a design fails to clear its state, it decodes a garbled address. Back-to-back reads with select held high expose a counter that is off by one at the wrap. A non-read opcode must set a flag that later good reads leave set, and it must return zeros. Random addresses, mixed with the table's corner words 0, 7, 8, 9 and 255, catch byte swaps and a wrong bit order.

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader #(
  parameter int          ADDR_W  = 8,
  parameter logic [15:0] ID_WORD = 16'h8139,
  parameter logic [47:0] STATION = 48'h02_1A_3C_5E_7F_91
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_rd,
  output logic [7:0] cmd_rd,
  output logic       err
);
  localparam int PREFIX = ADDR_W + 4;
  localparam int TOTAL  = ADDR_W + 20;
  localparam int IDX_W  = $clog2(TOTAL + 1);

  function automatic logic [15:0] rom_word(input int unsigned a);
    case (a)
      0:       rom_word = ID_WORD;
      7:       rom_word = {STATION[39:32], STATION[47:40]};
      8:       rom_word = {STATION[23:16], STATION[31:24]};
      9:       rom_word = {STATION[7:0],   STATION[15:8]};
      default: rom_word = 16'h0000;
    endcase
  endfunction

  logic [7:1]        ctrl_q;
  logic              dout_q, err_q;
  logic [7:0]        cmd_q;
  logic [PREFIX-1:0] shift_q;
  logic [IDX_W-1:0]  idx_q;
  logic [15:0]       word_q;

  wire ctrl_wr  = wr_en && !wr_sel;
  wire clk_rise = ctrl_wr && wr_data[2] && !ctrl_q[2];
  wire sel_rise = ctrl_wr && wr_data[3] && !ctrl_q[3];

  wire [PREFIX-1:0] shift_base = sel_rise ? '0 : shift_q;
  wire [IDX_W-1:0]  idx_base   = sel_rise ? '0 : idx_q;
  wire [PREFIX-1:0] shift_nx   = {shift_base[PREFIX-2:0], wr_data[1]};

  wire              in_prefix = idx_base < IDX_W'(PREFIX);
  wire              at_decode = idx_base == IDX_W'(PREFIX - 1);
  wire [3:0]        opcode    = shift_nx[PREFIX-1 -: 4];
  wire [ADDR_W-1:0] addr_f    = shift_nx[ADDR_W-1:0];
  wire              is_read   = opcode == 4'b0110;
  wire [IDX_W-1:0]  idx_inc   = idx_base + 1'b1;
  wire              wrap      = idx_inc == IDX_W'(TOTAL);
  wire [IDX_W-1:0]  bpos      = IDX_W'(PREFIX + 15) - idx_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      dout_q  <= 1'b0;
      err_q   <= 1'b0;
      cmd_q   <= '0;
      shift_q <= '0;
      idx_q   <= '0;
      word_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data[7:1];
      if (wr_en && wr_sel) cmd_q <= wr_data & 8'hEF;
      if (clk_rise) begin
        shift_q <= in_prefix ? shift_nx : shift_base;
        if (at_decode) begin
          word_q <= is_read ? rom_word(32'(addr_f)) : 16'h0000;
          if (!is_read) err_q <= 1'b1;
        end
        if (!in_prefix) dout_q <= word_q[bpos[3:0]];
        if (wrap) begin
          idx_q   <= '0;
          shift_q <= '0;
        end else begin
          idx_q <= idx_inc;
        end
      end else if (sel_rise) begin
        shift_q <= '0;
        idx_q   <= '0;
      end
    end
  end

  assign ctrl_rd = {ctrl_q, dout_q};
  assign cmd_rd  = cmd_q;
  assign err     = err_q;
endmodule

module mw_eeprom_reader_chk #(
  parameter int TOTAL = 28,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [7:0]       wr_data,
  input logic [7:0]       ctrl_rd,
  input logic [7:0]       cmd_rd,
  input logic             err,
  input logic [IDX_W-1:0] idx_q
);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R2
  dout_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !(wr_data[2] && !ctrl_rd[2])) |=> $stable(ctrl_rd[0]));
  // R2
  idx_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_sel) |=> $stable(idx_q));
  // R3
  sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[3] && !ctrl_rd[3] && !(wr_data[2] && !ctrl_rd[2]))
    |=> idx_q == '0);
  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(TOTAL));
  // R10
  rst_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (cmd_rd == ($past(wr_data) & 8'hEF)));
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk #(.TOTAL(ADDR_W + 20), .IDX_W($clog2(ADDR_W + 21))) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ctrl_rd(ctrl_rd), .cmd_rd(cmd_rd), .err(err), .idx_q(idx_q)
);

// File: tb/mw_eeprom_reader_bench.sv
module mw_eeprom_reader_bench;
  localparam logic [47:0] STN = 48'h02_1A_3C_5E_7F_91;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl_rd, cmd_rd;
  logic       err;
  int         checks = 0;
  int         errors = 0;
  int         cycles = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  mw_eeprom_reader #(.ADDR_W(8), .ID_WORD(16'h8139), .STATION(STN)) u_mw_eeprom_reader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .cmd_rd(cmd_rd), .err(err)
  );

  function automatic logic [7:0] sbyte(input int i);
    return STN[47 - 8*i -: 8];
  endfunction

  function automatic logic [15:0] exp_word(input logic [7:0] a);
    case (a)
      8'd0:    return 16'h8139;
      8'd7:    return {sbyte(1), sbyte(0)};
      8'd8:    return {sbyte(3), sbyte(2)};
      8'd9:    return {sbyte(5), sbyte(4)};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic edge_bit(input logic din, output logic dout);
    logic [3:0] hi;
    logic noisy;
    hi = 4'($urandom);
    noisy = ($urandom % 3) == 0;
    wr(1'b0, {hi, 1'b1, 1'b0, din, 1'b0});
    if (noisy) wr(1'b0, {hi, 1'b1, 1'b0, ~din, 1'b1});
    wr(1'b0, {hi, 1'b1, 1'b1, din, 1'b0});
    if (noisy) wr(1'b0, {hi, 1'b1, 1'b1, ~din, 1'b1});
    dout = ctrl_rd[0];
    if (noisy) check("R11 upper bits", 32'(ctrl_rd[7:4]), 32'(hi));
  endtask

  task automatic transact(input logic [3:0] op, input logic [7:0] a, output logic [15:0] w);
    logic [11:0] pre;
    logic b;
    pre = {op, a};
    w = '0;
    for (int i = 11; i >= 0; i--) edge_bit(pre[i], b);
    for (int k = 0; k < 16; k++) begin
      edge_bit(1'b0, b);
      w = {w[14:0], b};
    end
  endtask

  initial begin
    logic [15:0] w;
    logic [7:0]  a;
    logic        b;
    logic        hold;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctrl", 32'(ctrl_rd), 32'h0);
    check("R1 cmd", 32'(cmd_rd), 32'h0);
    check("R1 err", 32'(err), 32'h0);

    wr(1'b1, 8'hFF);
    check("R10 bit4 clear", 32'(cmd_rd), 32'hEF);
    wr(1'b1, 8'h10);
    check("R10 only reset bit", 32'(cmd_rd), 32'h00);
    wr(1'b1, 8'h5A);
    check("R10 passthrough", 32'(cmd_rd), 32'h4A);

    wr(1'b0, 8'h08);
    foreach (w[i]) w[i] = 1'b0;
    transact(4'b0110, 8'd0, w);
    check("R7 R4 R5 id word", 32'(w), 32'h8139);
    transact(4'b0110, 8'd7, w);
    check("R7 R6 word7", 32'(w), 32'(exp_word(8'd7)));
    transact(4'b0110, 8'd8, w);
    check("R7 R6 word8", 32'(w), 32'(exp_word(8'd8)));
    transact(4'b0110, 8'd9, w);
    check("R7 R6 word9", 32'(w), 32'(exp_word(8'd9)));
    transact(4'b0110, 8'd255, w);
    check("R7 word255", 32'(w), 32'h0);
    check("R8 no err yet", 32'(err), 32'h0);

    hold = ctrl_rd[0];
    wr(1'b0, {4'h0, 1'b1, 1'b0, 1'b1, ~hold});
    check("R9 dout ignored clk low", 32'(ctrl_rd[0]), 32'(hold));
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h09);
    check("R9 dout ignored sel rise", 32'(ctrl_rd[0]), 32'(hold));

    for (int i = 0; i < 5; i++) edge_bit(i[0], b);
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h08);
    transact(4'b0110, 8'd8, w);
    check("R3 restart after abort", 32'(w), 32'(exp_word(8'd8)));

    for (int n = 0; n < 16; n++) begin
      a = 8'($urandom);
      if (n % 4 == 0) a = 8'(6 + n / 4);
      transact(4'b0110, a, w);
      check("R4 R5 R2 random read", 32'(w), 32'(exp_word(a)));
    end
    check("R8 still clear", 32'(err), 32'h0);

    transact(4'b0111, 8'd0, w);
    check("R8 bad op zeros", 32'(w), 32'h0);
    check("R8 err set", 32'(err), 32'h1);
    transact(4'b0110, 8'd0, w);
    check("R8 good read after err", 32'(w), 32'h8139);
    check("R8 err sticky", 32'(err), 32'h1);
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      done = 1'b1;
    end
  end

  initial begin
    wait (done);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule